// File: doc/BRIEF.md
# Three-Lane Rotating Vector Multiplier

This block multiplies two three-component vectors lane by lane, with one lane per axis. Each lane owns an operand bank and a multiplier. Bank 0 holds x components, bank 1 holds y components and bank 2 holds z components. A rotation network sits between the banks and the multipliers. It lets each lane take its operand from a different axis's bank, so all three lanes can form cross-axis products at once. One example is the set ay*vz, az*vx and ax*vy.

Software or a sequencer fills the operand banks through a load port, then issues one microinstruction on a start pulse. The microinstruction names two source addresses, a rotation for each operand and a destination address. The operation runs in four steps: fetch the left operands, fetch the right operands, multiply in all lanes, and write the three products into the result banks. The result banks can be read back at any time through a combinational read port.

Top module: `vecmul3_rot`

## Requirements
- R1: While reset is low and on the first cycle after it, `busy` and `done` are 0 and every result word reads as zero.
- R2: A load writes bits [15:0] of `ld_data` into the x bank (bank 0), bits [31:16] into the y bank (bank 1) and bits [47:32] into the z bank (bank 2), all at `ld_addr`. With both rotations 0, lane k (result bits [16k+15:16k]) receives operand-a component k times operand-b component k.
- R3: Lane k reads its left operand from bank (k + rot_a) mod 3 at `src_a`, and its right operand from bank (k + rot_b) mod 3 at `src_b`.
- R4: A rotation code of 3 gives the same result as code 0 (identity).
- R5: Operands are signed Q8.8. Each product is the full signed product shifted right arithmetically by 8, and the low 16 bits of that shifted value are kept.
- R6: After `start` is sampled in idle, `busy` is high for exactly 4 cycles. `done` is then high for exactly one cycle, with `busy` low. The new results can be read during that cycle.
- R7: A `start` pulse sampled while `busy` is high is ignored. It causes no extra `done` and no write to its destination.
- R8: In each operand fetch step, every bank is read by exactly one lane.
- R9: A load sampled while `busy` is high is ignored and leaves the operand banks unchanged.
- R10: With rot_a=1 and rot_b=2, lanes x, y and z produce ay*vz, az*vx and ax*vy.
- R11: An operation writes only the result word at `dst`. All other result words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue the microinstruction on the fields below |
| src_a | input | 3 | Operand-a address |
| src_b | input | 3 | Operand-b address |
| rot_a | input | 2 | Rotation for operand a (0, 1, 2; 3 acts as 0) |
| rot_b | input | 2 | Rotation for operand b |
| dst | input | 3 | Result address |
| ld_en | input | 1 | Operand load enable |
| ld_addr | input | 3 | Operand load address |
| ld_data | input | 48 | Operand vector {z, y, x} |
| rd_addr | input | 3 | Result read address |
| rd_data | output | 48 | Result vector {z, y, x} at rd_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the write step |

## Verification
The assertions assume only that reset is held across at least one rising edge. They take `start` and `ld_en` to be able to arrive in any cycle, including while `busy` is high, and the properties on busy length, done pulse shape and bank distinctness must hold under that freedom. The stimulus changes every input on the falling edge. It sweeps all sixteen pairs of rotation codes over several data sets. It also deliberately places a start pulse and a load inside a running operation, so that the ignored-input cases reach the checker.

// File: rtl/vm_pkg.sv
// Package: shared constants and the sequencer state type for the
// three-lane rotating vector multiplier.
// Assumes: lane count fixed at three (one per spatial axis).
package vm_pkg;
    localparam int LANES = 3;
    localparam int ROT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LDA,
        ST_LDB,
        ST_MUL,
        ST_WR
    } vm_state_t;
endpackage

// File: rtl/vm_bank.sv
// Module: single-write, single-async-read word bank.
// Assumes: one access port per bank is enough because the router never
// steers two lanes to the same bank in one step. CLEAR selects whether
// the storage resets to zero.
module vm_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter bit CLEAR  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (CLEAR) begin : g_clear
            // Purpose: storage write with synchronous clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (we) begin
                    mem[waddr] <= wdata;
                end
            end
        end else begin : g_plain
            // Purpose: storage write without reset
            always_ff @(posedge clk) begin
                if (we) mem[waddr] <= wdata;
            end
        end
    endgenerate

    // Purpose: asynchronous read
    assign rdata = mem[raddr];
endmodule

// File: rtl/vm_router.sv
// Module: rotation network from the axis banks to the lane inputs.
// Lane k takes bank (k + rot) mod LANES; a code of LANES or above acts
// as identity. Also reports a one-hot bank select per lane.
// Assumes: LANES fits in the rotation code width.
module vm_router
    import vm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [ROT_W-1:0]                rot,
    input  logic [LANES-1:0][DATA_W-1:0]    bank_q,
    output logic [LANES-1:0][DATA_W-1:0]    lane_d,
    output logic [LANES-1:0][LANES-1:0]     lane_sel
);
    localparam int IDX_W = $clog2(2 * LANES);

    logic [IDX_W-1:0] eff_rot;

    // Purpose: fold illegal rotation codes onto identity
    always_comb begin
        if (int'(rot) >= LANES) eff_rot = '0;
        else                    eff_rot = IDX_W'(rot);
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [IDX_W-1:0] sum;
            logic [IDX_W-1:0] idx;
            // Purpose: modular bank index and steering for lane k
            always_comb begin
                sum = IDX_W'(k) + eff_rot;
                idx = (int'(sum) >= LANES) ? sum - IDX_W'(LANES) : sum;
                lane_d[k]   = bank_q[idx];
                lane_sel[k] = '0;
                lane_sel[k][idx] = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/vm_lane_mul.sv
// Module: one lane's fixed-point multiplier with registered product.
// Product is the signed full product shifted right arithmetically by
// FRAC_W, truncated to DATA_W bits.
// Assumes: FRAC_W < DATA_W.
module vm_lane_mul #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic        [DATA_W-1:0] p
);
    localparam int FULL_W = 2 * DATA_W;

    logic signed [FULL_W-1:0] full;
    logic signed [FULL_W-1:0] scaled;

    // Purpose: full-width signed product and Q scaling
    always_comb begin
        full   = FULL_W'(a) * FULL_W'(b);
        scaled = full >>> FRAC_W;
    end

    // Purpose: capture the truncated product in the multiply step
    always_ff @(posedge clk) begin
        if (!rst_n)  p <= '0;
        else if (en) p <= scaled[DATA_W-1:0];
    end
endmodule

// File: rtl/vecmul3_rot.sv
// Module: three-lane rotating vector multiplier (top).
// Sequence per microinstruction: fetch left operands, fetch right
// operands, multiply, write results; busy spans those four cycles and
// done pulses once afterward.
// Assumes: the instruction fields are valid in the cycle start is high;
// they are latched then.
module vecmul3_rot
    import vm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       src_a,
    input  logic [ADDR_W-1:0]       src_b,
    input  logic [ROT_W-1:0]        rot_a,
    input  logic [ROT_W-1:0]        rot_b,
    input  logic [ADDR_W-1:0]       dst,
    input  logic                    ld_en,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [LANES*DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*DATA_W-1:0] rd_data,
    output logic                    busy,
    output logic                    done
);
    vm_state_t state, state_nx;

    logic [ADDR_W-1:0] sa_q, sb_q, sd_q;
    logic [ROT_W-1:0]  ra_q, rb_q;

    logic [ADDR_W-1:0]               op_addr;
    logic [ROT_W-1:0]                cur_rot;
    logic [LANES-1:0][DATA_W-1:0]    bank_q;
    logic [LANES-1:0][DATA_W-1:0]    route_d;
    logic [LANES-1:0][LANES-1:0]     route_sel;
    logic [LANES*LANES-1:0]          sel_flat;
    logic [LANES-1:0][DATA_W-1:0]    left_q, right_q, prod_q;
    logic                            op_we;

    // Purpose: next-state logic of the four-step sequencer
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_LDA;
            ST_LDA:  state_nx = ST_LDB;
            ST_LDB:  state_nx = ST_MUL;
            ST_MUL:  state_nx = ST_WR;
            ST_WR:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state, done pulse and instruction latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            sa_q  <= '0;
            sb_q  <= '0;
            sd_q  <= '0;
            ra_q  <= '0;
            rb_q  <= '0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_WR);
            if (state == ST_IDLE && start) begin
                sa_q <= src_a;
                sb_q <= src_b;
                sd_q <= dst;
                ra_q <= rot_a;
                rb_q <= rot_b;
            end
        end
    end

    assign busy    = (state != ST_IDLE);
    assign op_we   = ld_en && !busy;
    assign op_addr = (state == ST_LDB) ? sb_q : sa_q;
    assign cur_rot = (state == ST_LDB) ? rb_q : ra_q;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_axis
            vm_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR(1'b0)) u_opbank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (op_we),
                .waddr (ld_addr),
                .wdata (ld_data[k*DATA_W +: DATA_W]),
                .raddr (op_addr),
                .rdata (bank_q[k])
            );

            vm_lane_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (state == ST_MUL),
                .a     (left_q[k]),
                .b     (right_q[k]),
                .p     (prod_q[k])
            );

            vm_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR(1'b1)) u_resbank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (state == ST_WR),
                .waddr (sd_q),
                .wdata (prod_q[k]),
                .raddr (rd_addr),
                .rdata (rd_data[k*DATA_W +: DATA_W])
            );
        end
    endgenerate

    vm_router #(.DATA_W(DATA_W)) u_router (
        .rot      (cur_rot),
        .bank_q   (bank_q),
        .lane_d   (route_d),
        .lane_sel (route_sel)
    );

    assign sel_flat = route_sel;

    // Purpose: operand staging registers for the two fetch steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else begin
            if (state == ST_LDA) left_q  <= route_d;
            if (state == ST_LDB) right_q <= route_d;
        end
    end
endmodule

// File: rtl/vecmul3_rot_chk.sv
// Module: protocol and routing checker, bound into the top module.
// Assumes: reset held across at least one rising edge.
module vecmul3_rot_chk #(
    parameter int LN = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [LN*LN-1:0]   sel_flat
);
    logic [2:0] busy_cnt;
    logic [LN-1:0] bank_union;

    // Purpose: count cycles of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 3'd1;
        else           busy_cnt <= '0;
    end

    // Purpose: set of banks touched by all lanes in this step
    always_comb begin
        bank_union = '0;
        for (int k = 0; k < LN; k++) bank_union = bank_union | sel_flat[k*LN +: LN];
    end

    // R6: busy window is exactly four cycles
    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_cnt) == 3'd3);
    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < 3'd4);
    // R6: done follows the busy window, single cycle, with busy low
    assert_done_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: a busy window only opens from an accepted start
    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8: all banks covered, each lane one bank
    assert_bank_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(bank_union) == LN && $countones(sel_flat) == LN));
endmodule

bind vecmul3_rot vecmul3_rot_chk #(.LN(vm_pkg::LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sel_flat (sel_flat)
);

// File: tb/tb_vecmul3_rot.sv
module tb_vecmul3_rot;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  src_a, src_b, dst, ld_addr, rd_addr;
    logic [1:0]  rot_a, rot_b;
    logic        ld_en;
    logic [47:0] ld_data;
    logic [47:0] rd_data;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int opm [3][8];
    int resm [8][3];

    always #4 clk = ~clk;

    vecmul3_rot dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .rot_a(rot_a), .rot_b(rot_b), .dst(dst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sx16(input int v);
        logic [15:0] t;
        t = v[15:0];
        return int'($signed(t));
    endfunction

    function automatic int q88(input int a, input int b);
        int p;
        p = (a * b) >>> 8;
        return sx16(p);
    endfunction

    function automatic int gen(input int lane, input int addr, input int seed);
        return sx16((lane * 7919 + addr * 4253 + seed * 1237) ^ 32'h5a3c);
    endfunction

    function automatic int eff(input int r);
        return (r == 3) ? 0 : r;
    endfunction

    task automatic load_vec(input int a, input int x, input int y, input int z);
        ld_en   = 1'b1;
        ld_addr = 3'(a);
        ld_data = {16'(z), 16'(y), 16'(x)};
        @(negedge clk);
        ld_en = 1'b0;
        opm[0][a] = x; opm[1][a] = y; opm[2][a] = z;
    endtask

    task automatic check_res(input int d, input string req);
        rd_addr = 3'(d);
        #1;
        for (int k = 0; k < 3; k++) begin
            check(sx16(int'(rd_data[k*16 +: 16])) == resm[d][k], req,
                  sx16(int'(rd_data[k*16 +: 16])), resm[d][k]);
        end
    endtask

    // poke: inject a start to dst2 and a load to sa during the busy window
    task automatic run_op(input int sa, input int sb, input int ra, input int rb,
                          input int d, input bit poke, input int d2, input string req);
        start = 1'b1;
        src_a = 3'(sa); src_b = 3'(sb);
        rot_a = 2'(ra); rot_b = 2'(rb); dst = 3'(d);
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R6 busy after start", busy, 1);
        @(negedge clk);
        if (poke) begin
            start = 1'b1; dst = 3'(d2);
            ld_en = 1'b1; ld_addr = 3'(sa); ld_data = 48'h7fff_7fff_7fff;
        end
        check(busy && !done, "R6 busy cycle 2", busy, 1);
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        check(busy && !done, "R6 busy cycle 3", busy, 1);
        @(negedge clk);
        check(busy && !done, "R6 busy cycle 4", busy, 1);
        @(negedge clk);
        check(done && !busy, "R6 done pulse", done, 1);
        for (int k = 0; k < 3; k++)
            resm[d][k] = q88(opm[(k + eff(ra)) % 3][sa], opm[(k + eff(rb)) % 3][sb]);
        check_res(d, req);
        @(negedge clk);
        check(!done && !busy, poke ? "R7 no second done" : "R6 done single", done, 0);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ld_en = 1'b0;
        src_a = '0; src_b = '0; dst = '0; rot_a = '0; rot_b = '0;
        ld_addr = '0; ld_data = '0; rd_addr = '0;
        for (int a = 0; a < 8; a++) for (int k = 0; k < 3; k++) resm[a][k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1 idle in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", done, 0);
        for (int a = 0; a < 8; a++) check_res(a, "R1 results clear");

        // Corner operands at address 7 and simple values at 6
        load_vec(7, -32768, 32767, -256);
        load_vec(6, 256, 512, -768);
        for (int a = 0; a < 6; a++) load_vec(a, gen(0, a, 1), gen(1, a, 1), gen(2, a, 1));

        // R2: identity lane pairing
        run_op(6, 6, 0, 0, 0, 1'b0, 0, "R2 identity lanes");
        // R5: saturation-free truncation corners
        run_op(7, 7, 0, 0, 1, 1'b0, 0, "R5 Q8.8 truncation");
        run_op(7, 6, 0, 0, 2, 1'b0, 0, "R5 signed mixed");
        // R10: cross-product terms
        run_op(0, 1, 1, 2, 3, 1'b0, 0, "R10 cross terms");

        // R3 / R4: all rotation pairs, several data sets
        for (int s = 2; s < 5; s++) begin
            for (int a = 0; a < 6; a++) load_vec(a, gen(0, a, s), gen(1, a, s), gen(2, a, s));
            for (int ra = 0; ra < 4; ra++) begin
                for (int rb = 0; rb < 4; rb++) begin
                    run_op((ra + s) % 6, (rb + 2 * s) % 6, ra, rb, (ra * 4 + rb) % 5,
                           1'b0, 0, (ra == 3 || rb == 3) ? "R4 code 3 identity" : "R3 rotation");
                end
            end
        end

        // R11: untouched result words
        for (int a = 0; a < 8; a++) check_res(a, "R11 other words kept");

        // R7 / R9: start and load during busy are ignored
        resm[7][0] = resm[7][0];
        run_op(2, 3, 1, 0, 5, 1'b1, 7, "R7 op with injected start");
        check_res(7, "R7 ignored start no write");
        run_op(2, 2, 0, 0, 6, 1'b0, 0, "R9 load in busy ignored");
        for (int a = 0; a < 8; a++) check_res(a, "R11 final map");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule